// File: doc/BRIEF.md
# Center-Aligned Up/Down Timer Counter

This block is the counting core of a timer that runs in a triangle. The count climbs from zero to the active reload value, then drops back to zero, and repeats. It moves one step on each cycle where the block is enabled and the count tick input is high. The tick comes from an external prescaler, which is not part of this block. At the top turning point the block gives a one-cycle overflow pulse. At the bottom turning point it gives a one-cycle underflow pulse. Either pulse sets a sticky update flag, and software clears that flag with a strobe. A direction output shows whether the count is rising or falling. Only the hardware changes it.

Software writes a new reload value into a preload register. The counter never compares against that register directly. It uses a shadow copy, and the shadow copy takes the preload value only on an update event. An update event is an overflow, an underflow or a software update request, so a period in progress keeps its limit. A software update request also restarts the count at zero, rising, from any position.

The direction is held by a two-state machine. Its states are `DIR_UP` and `DIR_DOWN`, and it has these transitions:
- `turn_top`: from `DIR_UP` to `DIR_DOWN` on an overflow step.
- `turn_bottom`: from `DIR_DOWN` to `DIR_UP` on an underflow step.
- `restart`: from any state to `DIR_UP` on a software update request.

Top module: `tri_timer`

## Requirements
- R1: After reset, `count` is 0, `dir_down` is 0, `ovf`, `unf` and `upd_flag` are 0, and the active reload value equals the parameter `RELOAD_INIT`.
- R2: Rising phase, `dir_down` = 0.
  - Each cycle with `en` = 1 and `tick` = 1 adds 1 to `count`.
  - On the step that makes `count` equal to the active reload value, `ovf` is 1 for exactly that cycle, and `dir_down` becomes 1 on the same clock edge.
- R3: Falling phase, `dir_down` = 1.
  - Each enabled tick subtracts 1 from `count`.
  - On the step that makes `count` 0, `unf` is 1 for exactly that cycle, and `dir_down` becomes 0 on the same edge.
- R4: With `en` = 0 or `tick` = 0, and no software update request, `count`, `dir_down`, `ovf` and `unf` do not advance. Both pulses read 0.
- R5: A cycle with `sw_upd` = 1 sets `count` to 0 and `dir_down` to 0 on the next edge.
  - This holds whatever `en`, `tick` and the current direction are.
  - The request produces no `ovf` or `unf` pulse.
  - The shadow takes the preload value.
- R6: `upd_flag` becomes 1 on the edge where `ovf` or `unf` rises, and stays 1 until a cycle with `flag_clr` = 1. That cycle clears it on the next edge.
- R7: If `flag_clr` = 1 in the same cycle as a step that produces `ovf` or `unf`, `upd_flag` is 1 after that edge.
- R8: Reload writes take effect only at the next update event.
  - A write with `rld_wr` = 1 stores `rld_data` in the preload register.
  - The active reload value changes only at the next overflow, underflow or software update request.
  - A write made during a rising phase therefore does not move the top of that phase.
- R9: While the active reload value is 0 and the count is 0 rising, enabled ticks leave `count` at 0 and give no `ovf` or `unf` pulse.
- R10: `dir_down` changes only on an edge that also raises `ovf` or `unf`, or on the edge after a cycle with `sw_upd` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Counter enable |
| tick | input | 1 | Prescaled count tick, one step per high cycle |
| rld_wr | input | 1 | Write strobe for the preload register |
| rld_data | input | CNT_W | New reload value |
| sw_upd | input | 1 | Software update request: restart at 0, rising, and load the shadow |
| flag_clr | input | 1 | Clear strobe for the update flag |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | Direction: 0 rising, 1 falling |
| ovf | output | 1 | One-cycle pulse when the count reaches the top |
| unf | output | 1 | One-cycle pulse when the count reaches 0 going down |
| upd_flag | output | 1 | Sticky update-event flag |

## Verification
The bench builds the block with `CNT_W` = 6 and `RELOAD_INIT` = 3.

With a reload of 3, a full triangle takes only six ticks. This leaves room to check, in each test:
- the exact cycle of each pulse,
- a deferred reload taking effect one period late,
- a software restart in the middle of a falling phase.

The 6-bit width also brings the largest reload value, 63, within reach. The bench uses it to run a full climb to the all-ones count without wrapping.

// File: rtl/tri_cnt_pkg.sv
package tri_cnt_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tri_dir_e;

endpackage

// File: rtl/tri_reload_shadow.sv
module tri_reload_shadow #(
    parameter int CNT_W       = 16,
    parameter int RELOAD_INIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             take,
    output logic [CNT_W-1:0] shadow_q
);
    localparam logic [CNT_W-1:0] INIT_V = CNT_W'(RELOAD_INIT);

    logic [CNT_W-1:0] preload_q;

    // Preload register: written by software at any time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= INIT_V;
        end else if (wr) begin
            preload_q <= wdata;
        end
    end

    // Shadow copy: follows the preload only on an update event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= INIT_V;
        end else if (take) begin
            shadow_q <= preload_q;
        end
    end
endmodule

// File: rtl/tri_dir_fsm.sv
module tri_dir_fsm
    import tri_cnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     turn_top,
    input  logic     turn_bottom,
    output tri_dir_e state_q,
    output logic     dir_down
);
    tri_dir_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = DIR_UP;
        end else begin
            unique case (state_q)
                DIR_UP:   if (turn_top)    state_d = DIR_DOWN;
                DIR_DOWN: if (turn_bottom) state_d = DIR_UP;
                default:  state_d = DIR_UP;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_UP;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            DIR_DOWN: dir_down = 1'b1;
            default:  dir_down = 1'b0;
        endcase
    end
endmodule

// File: rtl/tri_count_core.sv
module tri_count_core
    import tri_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  tri_dir_e         dir,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count_q,
    output logic             at_top,
    output logic             at_bottom,
    output logic             ovf_q,
    output logic             unf_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             parked;
    logic             adv;
    logic [CNT_W-1:0] count_d;

    // Rising with the count already at or above the limit: nothing to do.
    // This covers a zero limit.
    assign parked = (dir == DIR_UP) && (count_q >= limit);
    assign adv    = step && !restart && !parked;

    always_comb begin
        at_top    = 1'b0;
        at_bottom = 1'b0;
        count_d   = count_q;
        if (restart) begin
            count_d = '0;
        end else if (adv) begin
            unique case (dir)
                DIR_UP: begin
                    count_d = count_q + ONE;
                    at_top  = (count_d == limit);
                end
                DIR_DOWN: begin
                    count_d   = count_q - ONE;
                    at_bottom = (count_d == '0);
                end
                default: count_d = count_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            ovf_q   <= at_top;
            unf_q   <= at_bottom;
        end
    end
endmodule

// File: rtl/tri_event_flag.sv
module tri_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);
    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tri_cnt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int RELOAD_INIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_data,
    input  logic             sw_upd,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             ovf,
    output logic             unf,
    output logic             upd_flag
);
    tri_dir_e         dir_q;
    logic [CNT_W-1:0] limit;
    logic             at_top;
    logic             at_bottom;
    logic             upd_event;

    assign upd_event = at_top || at_bottom || sw_upd;

    tri_reload_shadow #(
        .CNT_W       (CNT_W),
        .RELOAD_INIT (RELOAD_INIT)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (rld_wr),
        .wdata    (rld_data),
        .take     (upd_event),
        .shadow_q (limit)
    );

    tri_dir_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (sw_upd),
        .turn_top    (at_top),
        .turn_bottom (at_bottom),
        .state_q     (dir_q),
        .dir_down    (dir_down)
    );

    tri_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (en && tick),
        .restart   (sw_upd),
        .dir       (dir_q),
        .limit     (limit),
        .count_q   (count),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .ovf_q     (ovf),
        .unf_q     (unf)
    );

    tri_event_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (at_top || at_bottom),
        .clr    (flag_clr),
        .flag_q (upd_flag)
    );
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tick,
    input logic             sw_upd,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             ovf,
    input logic             unf,
    input logic             upd_flag
);
    // R2: an overflow pulse comes together with the turn to falling.
    a_r2_ovf_turns_down: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> dir_down);

    // R3: an underflow pulse shows a zero count and the turn to rising.
    a_r3_unf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (count == '0 && !dir_down));

    // R4: no tick or no enable, and no restart: nothing moves.
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en && tick) && !sw_upd) |=> ($stable(count) && $stable(dir_down) && !ovf && !unf));

    // R5: a software request restarts at zero, rising, with no pulse.
    a_r5_sw_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd |=> (count == '0 && !dir_down && !ovf && !unf));

    // R6: every pulse leaves the flag set.
    a_r6_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || unf) |-> upd_flag);

    // R6: a clear strobe drops the flag unless an event arrives with it (R7).
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!upd_flag || ovf || unf));

    // R2, R3: the two turning points never coincide.
    a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    // R10: direction changes only at a turning point or on a restart.
    a_r10_dir_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_down != $past(dir_down)) |-> (ovf || unf || $past(sw_upd)));
endmodule

bind tri_timer tri_timer_chk #(.CNT_W(CNT_W)) u_tri_timer_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick     (tick),
    .sw_upd   (sw_upd),
    .flag_clr (flag_clr),
    .count    (count),
    .dir_down (dir_down),
    .ovf      (ovf),
    .unf      (unf),
    .upd_flag (upd_flag)
);

// File: tb/test_tri_timer.sv
module test_tri_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 6;
    localparam int INIT_RLD   = 3;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         tick = 1'b0;
    logic         rld_wr = 1'b0;
    logic [W-1:0] rld_data = '0;
    logic         sw_upd = 1'b0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] count;
    logic         dir_down;
    logic         ovf;
    logic         unf;
    logic         upd_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_timer #(.CNT_W(W), .RELOAD_INIT(INIT_RLD)) i_tri_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .rld_wr   (rld_wr),
        .rld_data (rld_data),
        .sw_upd   (sw_upd),
        .flag_clr (flag_clr),
        .count    (count),
        .dir_down (dir_down),
        .ovf      (ovf),
        .unf      (unf),
        .upd_flag (upd_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare the whole observable state in one call.
    task automatic chk_all(input string req, input int c, input int d, input int o,
                           input int u, input int f);
        chk(req, "count", int'(count), c);
        chk(req, "dir_down", int'(dir_down), d);
        chk(req, "ovf", int'(ovf), o);
        chk(req, "unf", int'(unf), u);
        chk(req, "upd_flag", int'(upd_flag), f);
    endtask

    // Inputs change at the falling edge. Results are read at the next falling edge.
    task automatic step_once();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reload(input int v);
        rld_wr = 1'b1;
        rld_data = W'(v);
        @(negedge clk);
        rld_wr = 1'b0;
    endtask

    task automatic sw_request();
        sw_upd = 1'b1;
        @(negedge clk);
        sw_upd = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk_all("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_full_period();
        en = 1'b1;
        step_once(); chk_all("R2", 1, 0, 0, 0, 0);
        step_once(); chk_all("R2", 2, 0, 0, 0, 0);
        step_once(); chk_all("R2", 3, 1, 1, 0, 1);
        step_once(); chk_all("R3", 2, 1, 0, 0, 1);
        step_once(); chk_all("R3", 1, 1, 0, 0, 1);
        step_once(); chk_all("R3", 0, 0, 0, 1, 1);
        step_once(); chk_all("R2", 1, 0, 0, 0, 1);
    endtask

    task automatic t_hold();
        en = 1'b0;
        for (int i = 0; i < 3; i++) step_once();
        chk_all("R4", 1, 0, 0, 0, 1);
        en = 1'b1;
        idle(3);
        chk_all("R4", 1, 0, 0, 0, 1);
    endtask

    task automatic t_flag();
        clear_flag();
        chk("R6", "flag after clear", int'(upd_flag), 0);
        step_once();
        chk("R6", "flag with no event", int'(upd_flag), 0);
        flag_clr = 1'b1;
        step_once();
        flag_clr = 1'b0;
        chk_all("R7", 3, 1, 1, 0, 1);
        idle(2);
        chk("R6", "flag sticky", int'(upd_flag), 1);
    endtask

    task automatic t_sw_restart();
        step_once();
        chk_all("R3", 2, 1, 0, 0, 1);
        sw_upd = 1'b1;
        step_once();
        sw_upd = 1'b0;
        chk_all("R5", 0, 0, 0, 0, 1);
        en = 1'b0;
        step_once(); step_once();
        chk("R4", "count held", int'(count), 0);
        en = 1'b1;
        step_once(); step_once();
        en = 1'b0;
        sw_request();
        chk_all("R5", 0, 0, 0, 0, 1);
        en = 1'b1;
    endtask

    task automatic t_preload();
        clear_flag();
        step_once();
        write_reload(5);
        step_once();
        step_once();
        chk_all("R8", 3, 1, 1, 0, 1);
        for (int i = 0; i < 3; i++) step_once();
        chk_all("R8", 0, 0, 0, 1, 1);
        for (int i = 0; i < 4; i++) step_once();
        chk_all("R8", 4, 0, 0, 0, 1);
        step_once();
        chk_all("R8", 5, 1, 1, 0, 1);
    endtask

    task automatic t_zero_reload();
        write_reload(0);
        sw_request();
        clear_flag();
        for (int i = 0; i < 5; i++) begin
            step_once();
            chk_all("R9", 0, 0, 0, 0, 0);
        end
    endtask

    task automatic t_max_reload();
        int max_v = (1 << W) - 1;
        write_reload(max_v);
        sw_request();
        for (int i = 0; i < max_v - 1; i++) step_once();
        chk_all("R2", max_v - 1, 0, 0, 0, 0);
        step_once();
        chk_all("R2", max_v, 1, 1, 0, 1);
        step_once();
        chk_all("R10", max_v - 1, 1, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_period();
        t_hold();
        t_flag();
        t_sw_restart();
        t_preload();
        t_zero_reload();
        t_max_reload();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule